// File: doc/BRIEF.md
# Nested-Loop Array Summing Accelerator

This block is a small compute engine that a host starts with a single pulse. Before the pulse, the environment places a two-dimensional array of unsigned words in an external shared memory. The engine then walks that array with an outer loop over rows and an inner loop over columns. It fetches every element through a strobed read cycle and keeps a running sum. When the walk ends, it stores the sum through a strobed write cycle into the word that follows the array.

Completion uses a four-phase handshake. When the write finishes, busy drops and done rises, and the sum is shown on the result output. Done and the result hold until the host answers with results_read, and the engine then goes back to idle. Start pulses that arrive during a run, or while done is waiting for the host, are ignored. The array size, the data and address widths, and the base address are all parameters.

Top module: `lsa_loop_accel`

## Requirements
- R1: After reset, busy, done, mem_rd and mem_wr are all low, and no memory strobe is issued until a start pulse is seen in idle. A start sampled high in idle makes busy high from the next cycle.
- R2: Each read raises mem_rd for exactly one cycle. The reads address BASE + row*COLS + col in row-major order, with the row as the outer loop. Read data is taken from mem_rdata in the cycle after the strobe.
- R3: mem_rd and mem_wr are never high together. Each run issues exactly one write strobe, for one cycle, to address BASE + ROWS*COLS, and mem_wdata carries the sum in that cycle.
- R4: The sum is the total of all ROWS*COLS elements, taken modulo 2^DW, so it wraps on overflow. That value ends up in the memory word after the array.
- R5: In the cycle after the write strobe, busy is low and done is high. Done and result stay unchanged while results_read is low, and busy and done are never high together.
- R6: results_read sampled high while done is high returns the block to idle in the next cycle, with done and busy low. results_read while done is low has no effect.
- R7: A start pulse while busy is high, or while done is high, neither restarts nor extends the run. The read count, the sum and the done state are unaffected.
- R8: A run makes exactly ROWS*COLS reads, and busy stays high for exactly 2*ROWS*COLS+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| start | input | 1 | Host pulse that starts a run from idle |
| results_read | input | 1 | Host acknowledge of a finished result |
| busy | output | 1 | High while the run is in progress |
| done | output | 1 | High while the result waits for acknowledge |
| result | output | DW | Sum of the array elements |
| mem_addr | output | AW | Shared memory address |
| mem_wdata | output | DW | Shared memory write data |
| mem_rdata | input | DW | Shared memory read data, valid the cycle after mem_rd |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_wr | output | 1 | One-cycle write strobe |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a run or during the done phase. A restart there would be invisible on busy and done alone. To expose it, the stimulus fires start several cycles into a run and again while done waits. Every read address is matched against a queue of expected addresses, so any extra or restarted walk shows up as an unexpected read. The all-ones array drives the sum through wraparound, and a results_read given in idle confirms that the acknowledge is ignored there.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CAPT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_HOLD  = 3'd4
  } lsa_state_e;
endpackage

// File: rtl/lsa_index_gen.sv
module lsa_index_gen #(
  parameter int ROWS = 3,
  parameter int COLS = 4,
  parameter int AW   = 8,
  parameter int BASE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] rd_addr,
  output logic          last
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (clr) begin
      row_d = '0;
      col_d = '0;
    end else if (step) begin
      if (col_q == CW'(COLS - 1)) begin
        col_d = '0;
        row_d = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (clr || step) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign last    = (row_q == RW'(ROWS - 1)) && (col_q == CW'(COLS - 1));
  assign rd_addr = AW'(BASE) + AW'(row_q) * AW'(COLS) + AW'(col_q);

  // R2: the column counter never passes its last index
  a_r2_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= CW'(COLS - 1));
endmodule

// File: rtl/lsa_accum.sv
module lsa_accum #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] acc
);
  logic [DW-1:0] acc_d;

  always_comb begin
    acc_d = acc;
    if (clr)      acc_d = '0;
    else if (add) acc_d = acc + din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc <= '0;
    else if (clr || add) acc <= acc_d;
  end
endmodule

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic results_read,
  input  logic last,
  output logic clr,
  output logic step,
  output logic add,
  output logic rd,
  output logic wr,
  output logic busy,
  output logic done
);
  lsa_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    clr  = 1'b0;
    step = 1'b0;
    add  = 1'b0;
    rd   = 1'b0;
    wr   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        clr  = 1'b1;
        st_d = ST_READ;
      end
      ST_READ: begin
        rd   = 1'b1;
        st_d = ST_CAPT;
      end
      ST_CAPT: begin
        add = 1'b1;
        if (last) st_d = ST_WRITE;
        else begin
          step = 1'b1;
          st_d = ST_READ;
        end
      end
      ST_WRITE: begin
        wr   = 1'b1;
        st_d = ST_HOLD;
      end
      ST_HOLD: if (results_read) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q == ST_READ) || (st_q == ST_CAPT) || (st_q == ST_WRITE);
  assign done = (st_q == ST_HOLD);

  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && start) |=> busy);
  a_r3_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));
  a_r5_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (done && !busy));
  a_r5_done_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !results_read) |=> done);
  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && results_read) |=> (!done && !busy));
  a_r6_idle_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !start) |=> (!busy && !done));
endmodule

// File: rtl/lsa_loop_accel.sv
module lsa_loop_accel #(
  parameter int ROWS = 3,
  parameter int COLS = 4,
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int BASE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          results_read,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr
);
  localparam int        NELEM = ROWS * COLS;
  localparam logic [AW-1:0] WADDR = AW'(BASE + NELEM);

  logic          clr, step, add, last;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] acc;

  lsa_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .results_read(results_read),
    .last(last), .clr(clr), .step(step), .add(add),
    .rd(mem_rd), .wr(mem_wr), .busy(busy), .done(done)
  );

  lsa_index_gen #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .BASE(BASE)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .rd_addr(rd_addr), .last(last)
  );

  lsa_accum #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .add(add),
    .din(mem_rdata), .acc(acc)
  );

  assign mem_addr  = mem_wr ? WADDR : rd_addr;
  assign mem_wdata = acc;
  assign result    = acc;

  a_r2_read_in_array: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr >= AW'(BASE) && mem_addr < WADDR));
  a_r3_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == WADDR));
  a_r5_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !results_read) |=> $stable(result));
endmodule

// File: tb/lsa_loop_accel_tb_top.sv
module lsa_loop_accel_tb_top;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int DW   = 16;
  localparam int AW   = 8;
  localparam int BASE = 16;
  localparam int N    = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          results_read = 1'b0;
  logic          busy, done, mem_rd, mem_wr;
  logic [DW-1:0] result, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] mem [2**AW];

  int total = 0, bad = 0;
  int reads = 0, wr_cnt = 0, busy_cycles = 0;
  logic [AW-1:0] wr_addr_s;
  logic [DW-1:0] wr_data_s;
  logic          done_q = 1'b0;
  logic [AW-1:0] exp_addr [$];
  logic [DW-1:0] exp_sum  [$];

  always #5 clk = ~clk;

  lsa_loop_accel #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW), .BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .results_read(results_read),
    .busy(busy), .done(done), .result(result), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: read data returned the cycle after the strobe
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd && mem_wr) chk(0, "R3", "both strobes", 1, 0);
      if (mem_rd) begin
        reads++;
        if (exp_addr.size() == 0) chk(0, "R7", "unexpected read", 32'(mem_addr), 0);
        else begin
          logic [AW-1:0] a;
          a = exp_addr.pop_front();
          chk(mem_addr == a, "R2", "read address", 32'(mem_addr), 32'(a));
        end
      end
      if (mem_wr) begin
        wr_cnt++;
        wr_addr_s = mem_addr;
        wr_data_s = mem_wdata;
      end
      if (busy) busy_cycles++;
      if (done && !done_q) begin
        if (exp_sum.size() == 0) chk(0, "R7", "unexpected done", 1, 0);
        else begin
          logic [DW-1:0] s;
          s = exp_sum.pop_front();
          chk(result == s, "R4", "result sum", 32'(result), 32'(s));
        end
      end
      done_q <= done;
    end
  end

  task automatic run_case(input int kind, input bit inject);
    logic [DW-1:0] sum = '0;
    for (int i = 0; i < N; i++) begin
      logic [DW-1:0] v;
      case (kind)
        0: v = '0;
        1: v = DW'(i + 1);
        2: v = '1;
        default: v = DW'((i * 37 + 5) ^ (i << 9));
      endcase
      mem[BASE + i] = v;
      sum += v;
      exp_addr.push_back(AW'(BASE + i));
    end
    exp_sum.push_back(sum);
    reads = 0; wr_cnt = 0; busy_cycles = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", 32'(busy), 1);
    if (inject) begin
      repeat (5) @(negedge clk);
      start = 1'b1;                       // R7: start while busy
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R5", "busy low at done", 32'(busy), 0);
    @(negedge clk);
    chk(reads == N, "R8", "read count", 32'(reads), 32'(N));
    chk(busy_cycles == 2 * N + 1, "R8", "busy cycles", 32'(busy_cycles), 32'(2 * N + 1));
    chk(wr_cnt == 1, "R3", "write count", 32'(wr_cnt), 1);
    chk(wr_addr_s == AW'(BASE + N), "R3", "write address", 32'(wr_addr_s), 32'(BASE + N));
    chk(wr_data_s == sum, "R3", "write data", 32'(wr_data_s), 32'(sum));
    chk(mem[BASE + N] == sum, "R4", "stored sum", 32'(mem[BASE + N]), 32'(sum));
    start = 1'b1;                         // R7: start while done
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R5", "done held", 32'(done), 1);
    chk(result == sum, "R5", "result held", 32'(result), 32'(sum));
    chk(reads == N && !busy, "R7", "no restart in done", 32'(reads), 32'(N));
    results_read = 1'b1;
    @(negedge clk) results_read = 1'b0;
    chk(done == 1'b0 && busy == 1'b0, "R6", "idle after ack", 32'({busy, done}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1", "reset busy/done", 32'({busy, done}), 0);
    chk(!mem_rd && !mem_wr && reads == 0, "R1", "no strobe before start", 32'({mem_rd, mem_wr}), 0);
    results_read = 1'b1;                  // R6: acknowledge while idle
    @(negedge clk) results_read = 1'b0;
    @(negedge clk);
    chk(!busy && !done && reads == 0 && wr_cnt == 0, "R6", "idle ack ignored",
        32'({busy, done}), 0);
    run_case(0, 1'b0);
    run_case(1, 1'b1);
    run_case(2, 1'b0);
    run_case(3, 1'b1);
    run_case(1, 1'b0);
    chk(exp_addr.size() == 0 && exp_sum.size() == 0, "R8", "scoreboard drained",
        32'(exp_addr.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule